// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Byte Lanes

This block is a true dual-port memory with two fully independent ports, left and right, each running on its own clock. Every port registers its address, write data and controls on the rising edge of its clock. It then reads or writes an 18-bit word split into two 9-bit lanes. Both ports may reach any location in the same cycle, including the same word. A port is selected only when its active-low and active-high enables agree. Each lane has its own active-low select.

Each port has its own loadable burst address counter. It can be cleared, loaded from the address pins, stepped, or held, so a stream of consecutive words needs the address only once. Read data can leave through a flow-through path or through one extra output register, chosen per port. An asynchronous output enable gates what is presented. Instead of tri-state pins, each lane carries a valid flag next to the data bus, and a lane whose flag is low reads as zeros.

Top module: `dpram_dual_lane`

## Requirements
- R1: Both ports operate in the same cycle on any addresses. When one port writes a word that the other port reads in that same cycle, the reading port returns the contents from before the write. Two writes that touch different lanes of the same word both take effect.
- R2: Address, data, enables, lane selects, direction and mode are captured only on the rising edge of the port's clock. Changing them between edges does not alter the outputs.
- R3: A word is 18 bits. Bits 17..9 form the upper lane, selected by `*_hi_n` and reported on `*_lane_vld[1]`. Bits 8..0 form the lower lane, selected by `*_lo_n` and reported on `*_lane_vld[0]`.
- R4: A port is selected when the captured `*_en_n` is 0 and the captured `*_en` is 1. A deselected port writes nothing and holds both lane valid flags at 0.
- R5: With the port selected and `*_rnw` = 0, only the lanes whose select is 0 are written. The other lane of the word keeps its contents.
- R6: With the port selected and `*_rnw` = 1, only the lanes whose select is 0 raise their valid flag. Every lane whose flag is 0 shows all zeros on `*_dout`.
- R7: `*_oe_n` acts without a clock. While it is 1, both valid flags of that port are 0 and `*_dout` is zero.
- R8: With the captured `*_pipe` = 0 (flow-through), read data for a captured address is presented during the cycle that follows the capturing edge. With `*_pipe` = 1 (pipelined), the same data and valid flags appear one cycle later.
- R9: The port address is updated at each edge by the following priority. First, `*_clr_n` = 0 sets it to 0. Next, `*_load_n` = 0 takes `*_addr`. Next, `*_step_n` = 0 adds one. Otherwise the address holds. The counter runs whether or not the port is selected.
- R10: Stepping from address DEPTH-1 gives address 0.
- R11: A write takes effect at the end of its cycle. A read of the same word on the same port in the next cycle returns the new data.
- R12: While `rst_n` is 0, both ports have their addresses at 0, all valid flags at 0 and their output registers cleared. The memory contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset of both ports' registers |
| l_en_n | input | 1 | Left active-low port enable |
| l_en | input | 1 | Left active-high port enable |
| l_rnw | input | 1 | Left direction: 1 read, 0 write |
| l_hi_n | input | 1 | Left upper lane select, active low |
| l_lo_n | input | 1 | Left lower lane select, active low |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_pipe | input | 1 | Left read mode: 1 pipelined, 0 flow-through |
| l_load_n | input | 1 | Left counter load from address, active low |
| l_step_n | input | 1 | Left counter increment, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_addr | input | AW | Left external address |
| l_din | input | 18 | Left write data |
| l_dout | output | 18 | Left read data, zero in invalid lanes |
| l_lane_vld | output | 2 | Left per-lane valid, bit 1 upper, bit 0 lower |
| r_en_n | input | 1 | Right active-low port enable |
| r_en | input | 1 | Right active-high port enable |
| r_rnw | input | 1 | Right direction: 1 read, 0 write |
| r_hi_n | input | 1 | Right upper lane select, active low |
| r_lo_n | input | 1 | Right lower lane select, active low |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_pipe | input | 1 | Right read mode: 1 pipelined, 0 flow-through |
| r_load_n | input | 1 | Right counter load from address, active low |
| r_step_n | input | 1 | Right counter increment, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_addr | input | AW | Right external address |
| r_din | input | 18 | Right write data |
| r_dout | output | 18 | Right read data, zero in invalid lanes |
| r_lane_vld | output | 2 | Right per-lane valid, bit 1 upper, bit 0 lower |

## Verification
The two functions that meet in one cycle are a write on one port and a read of the same word on the other port. A companion case is both ports writing different lanes of one word. The bench provokes these by aiming both ports at a shared address in the same cycle, once with the reader in flow-through mode and once with it pipelined. A behavioural model holds the word's old value until the end of the cycle and judges the reader's data and lane flags against it. The next cycle confirms that the merged new word is visible from both sides.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;

  // Next burst address: wraps from the last word back to zero.
  function automatic logic [31:0] bump_addr(input logic [31:0] cur,
                                            input logic [31:0] depth);
    return (cur >= depth - 32'd1) ? 32'd0 : cur + 32'd1;
  endfunction

  // Active-low lane selects turned into an active-high mask (bit 1 = upper).
  function automatic lane_mask_t lane_sel(input logic hi_n, input logic lo_n);
    return {~hi_n, ~lo_n};
  endfunction

  // Zero every lane whose mask bit is clear.
  function automatic word_t lane_gate(input word_t d, input lane_mask_t m);
    word_t r;
    for (int i = 0; i < LANES; i++)
      r[i*LANE_W +: LANE_W] = m[i] ? d[i*LANE_W +: LANE_W] : '0;
    return r;
  endfunction

endpackage

// File: rtl/dpram_port_front.sv
module dpram_port_front
  import dpram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          en,
  input  logic          rnw,
  input  logic          hi_n,
  input  logic          lo_n,
  input  logic          pipe,
  input  logic          load_n,
  input  logic          step_n,
  input  logic          clr_n,
  input  logic [AW-1:0] addr_in,
  input  word_t         din,
  output logic [AW-1:0] addr_q,
  output word_t         wdata_q,
  output lane_mask_t    wr_lane,
  output lane_mask_t    rd_lane,
  output logic          pipe_q
);

  logic       sel_q;
  logic       rnw_q;
  lane_mask_t lanes_q;

  // Counter events, named for the assertions below.
  logic          cnt_clear;
  logic          cnt_load;
  logic          cnt_step;
  logic [AW-1:0] addr_nxt;

  assign cnt_clear = ~clr_n;
  assign cnt_load  = clr_n & ~load_n;
  assign cnt_step  = clr_n & load_n & ~step_n;

  always_comb begin
    if (cnt_clear)     addr_nxt = '0;
    else if (cnt_load) addr_nxt = addr_in;
    else if (cnt_step) addr_nxt = AW'(bump_addr(32'(addr_q), 32'(DEPTH)));
    else               addr_nxt = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sel_q   <= 1'b0;
      rnw_q   <= 1'b1;
      lanes_q <= '0;
      pipe_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_nxt;
      sel_q   <= ~en_n & en;
      rnw_q   <= rnw;
      lanes_q <= lane_sel(hi_n, lo_n);
      pipe_q  <= pipe;
      wdata_q <= din;
    end
  end

  assign wr_lane = {LANES{sel_q & ~rnw_q}} & lanes_q;
  assign rd_lane = {LANES{sel_q &  rnw_q}} & lanes_q;

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> addr_q == '0); // R9
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && !load_n |=> addr_q == $past(addr_in)); // R9
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && load_n && step_n |=> $stable(addr_q)); // R9
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && load_n && !step_n && (32'(addr_q) == DEPTH - 1) |=> addr_q == '0); // R10
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n || !en) |=> (wr_lane == '0) && (rd_lane == '0)); // R4

endmodule

// File: rtl/dpram_lvt_core.sv
module dpram_lvt_core
  import dpram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_l,
  input  lane_mask_t    wr_l,
  input  logic [AW-1:0] addr_l,
  input  word_t         wdata_l,
  output word_t         rdata_l,
  input  logic          clk_r,
  input  lane_mask_t    wr_r,
  input  logic [AW-1:0] addr_r,
  input  word_t         wdata_r,
  output word_t         rdata_r
);

  // One bank per writer and lane; a pair of toggle bits per word tells which
  // bank holds the latest value (equal: left bank, different: right bank).
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank_l [DEPTH];
    logic [LANE_W-1:0] bank_r [DEPTH];
    logic              tog_l  [DEPTH];
    logic              tog_r  [DEPTH];
    logic              pick_l_for_l;
    logic              pick_l_for_r;

    always_ff @(posedge clk_l) begin
      if (wr_l[g]) begin
        bank_l[addr_l] <= wdata_l[g*LANE_W +: LANE_W];
        tog_l[addr_l]  <= tog_r[addr_l];
      end
    end

    always_ff @(posedge clk_r) begin
      if (wr_r[g]) begin
        bank_r[addr_r] <= wdata_r[g*LANE_W +: LANE_W];
        tog_r[addr_r]  <= ~tog_l[addr_r];
      end
    end

    assign pick_l_for_l = (tog_l[addr_l] == tog_r[addr_l]);
    assign pick_l_for_r = (tog_l[addr_r] == tog_r[addr_r]);
    assign rdata_l[g*LANE_W +: LANE_W] = pick_l_for_l ? bank_l[addr_l] : bank_r[addr_l];
    assign rdata_r[g*LANE_W +: LANE_W] = pick_l_for_r ? bank_l[addr_r] : bank_r[addr_r];
  end

endmodule

// File: rtl/dpram_read_out.sv
module dpram_read_out
  import dpram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pipe_q,
  input  lane_mask_t rd_lane,
  input  word_t      rdata,
  input  logic       oe_n,
  output word_t      dout,
  output lane_mask_t dout_en
);

  word_t      pdata_q;
  lane_mask_t plane_q;
  lane_mask_t lane_live;
  word_t      data_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdata_q <= '0;
      plane_q <= '0;
    end else begin
      pdata_q <= rdata;
      plane_q <= rd_lane;
    end
  end

  assign lane_live = pipe_q ? plane_q : rd_lane;
  assign data_live = pipe_q ? pdata_q : rdata;
  assign dout_en   = lane_live & {LANES{~oe_n}};
  assign dout      = lane_gate(data_live, dout_en);

  AST_PIPE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_q && !oe_n |-> dout_en == $past(rd_lane)); // R8
  AST_PIPE_DATA_LO: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_q && dout_en[0] |-> dout[LANE_W-1:0] == $past(rdata[LANE_W-1:0])); // R8

endmodule

// File: rtl/dpram_dual_lane.sv
module dpram_dual_lane
  import dpram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_l,
  input  logic          clk_r,
  input  logic          rst_n,
  input  logic          l_en_n,
  input  logic          l_en,
  input  logic          l_rnw,
  input  logic          l_hi_n,
  input  logic          l_lo_n,
  input  logic          l_oe_n,
  input  logic          l_pipe,
  input  logic          l_load_n,
  input  logic          l_step_n,
  input  logic          l_clr_n,
  input  logic [AW-1:0] l_addr,
  input  logic [17:0]   l_din,
  output logic [17:0]   l_dout,
  output logic [1:0]    l_lane_vld,
  input  logic          r_en_n,
  input  logic          r_en,
  input  logic          r_rnw,
  input  logic          r_hi_n,
  input  logic          r_lo_n,
  input  logic          r_oe_n,
  input  logic          r_pipe,
  input  logic          r_load_n,
  input  logic          r_step_n,
  input  logic          r_clr_n,
  input  logic [AW-1:0] r_addr,
  input  logic [17:0]   r_din,
  output logic [17:0]   r_dout,
  output logic [1:0]    r_lane_vld
);

  logic [AW-1:0] addr_lq, addr_rq;
  word_t         wdata_lq, wdata_rq;
  word_t         rdata_l, rdata_r;
  lane_mask_t    wr_l, wr_r, rd_l, rd_r;
  logic          pipe_lq, pipe_rq;

  dpram_port_front #(.DEPTH(DEPTH), .AW(AW)) u_front_l (
    .clk(clk_l), .rst_n(rst_n), .en_n(l_en_n), .en(l_en), .rnw(l_rnw),
    .hi_n(l_hi_n), .lo_n(l_lo_n), .pipe(l_pipe), .load_n(l_load_n),
    .step_n(l_step_n), .clr_n(l_clr_n), .addr_in(l_addr), .din(l_din),
    .addr_q(addr_lq), .wdata_q(wdata_lq), .wr_lane(wr_l), .rd_lane(rd_l),
    .pipe_q(pipe_lq));

  dpram_port_front #(.DEPTH(DEPTH), .AW(AW)) u_front_r (
    .clk(clk_r), .rst_n(rst_n), .en_n(r_en_n), .en(r_en), .rnw(r_rnw),
    .hi_n(r_hi_n), .lo_n(r_lo_n), .pipe(r_pipe), .load_n(r_load_n),
    .step_n(r_step_n), .clr_n(r_clr_n), .addr_in(r_addr), .din(r_din),
    .addr_q(addr_rq), .wdata_q(wdata_rq), .wr_lane(wr_r), .rd_lane(rd_r),
    .pipe_q(pipe_rq));

  dpram_lvt_core #(.DEPTH(DEPTH), .AW(AW)) u_core (
    .clk_l(clk_l), .wr_l(wr_l), .addr_l(addr_lq), .wdata_l(wdata_lq), .rdata_l(rdata_l),
    .clk_r(clk_r), .wr_r(wr_r), .addr_r(addr_rq), .wdata_r(wdata_rq), .rdata_r(rdata_r));

  dpram_read_out u_out_l (
    .clk(clk_l), .rst_n(rst_n), .pipe_q(pipe_lq), .rd_lane(rd_l), .rdata(rdata_l),
    .oe_n(l_oe_n), .dout(l_dout), .dout_en(l_lane_vld));

  dpram_read_out u_out_r (
    .clk(clk_r), .rst_n(rst_n), .pipe_q(pipe_rq), .rd_lane(rd_r), .rdata(rdata_r),
    .oe_n(r_oe_n), .dout(r_dout), .dout_en(r_lane_vld));

  AST_OE_QUIET_L: assert property (@(posedge clk_l) disable iff (!rst_n)
    l_oe_n |-> (l_lane_vld == 2'b00) && (l_dout == '0)); // R7
  AST_OE_QUIET_R: assert property (@(posedge clk_r) disable iff (!rst_n)
    r_oe_n |-> (r_lane_vld == 2'b00) && (r_dout == '0)); // R7
  AST_ZERO_LANE_L: assert property (@(posedge clk_l) disable iff (!rst_n)
    !l_lane_vld[1] |-> l_dout[17:9] == '0); // R6

endmodule

// File: tb/dpram_dual_lane_tb.sv
module dpram_dual_lane_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int AW         = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          en_n[2], en[2], rnw[2], hi_n[2], lo_n[2], oe_n[2], pipe[2];
  logic          load_n[2], step_n[2], clr_n[2];
  logic [AW-1:0] addr[2];
  logic [17:0]   din[2];
  logic [17:0]   dout[2];
  logic [1:0]    vld[2];

  dpram_dual_lane #(.DEPTH(DEPTH)) dut_i (
    .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
    .l_en_n(en_n[0]), .l_en(en[0]), .l_rnw(rnw[0]), .l_hi_n(hi_n[0]), .l_lo_n(lo_n[0]),
    .l_oe_n(oe_n[0]), .l_pipe(pipe[0]), .l_load_n(load_n[0]), .l_step_n(step_n[0]),
    .l_clr_n(clr_n[0]), .l_addr(addr[0]), .l_din(din[0]), .l_dout(dout[0]), .l_lane_vld(vld[0]),
    .r_en_n(en_n[1]), .r_en(en[1]), .r_rnw(rnw[1]), .r_hi_n(hi_n[1]), .r_lo_n(lo_n[1]),
    .r_oe_n(oe_n[1]), .r_pipe(pipe[1]), .r_load_n(load_n[1]), .r_step_n(step_n[1]),
    .r_clr_n(clr_n[1]), .r_addr(addr[1]), .r_din(din[1]), .r_dout(dout[1]), .r_lane_vld(vld[1]));

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag     = "R12";
  bit    done    = 0;

  // Behavioural reference model.
  logic [17:0] m_mem [DEPTH];
  int          m_addr[2];
  bit          m_sel[2], m_rd[2], m_pipe[2];
  bit [1:0]    m_lanes[2], p_lanes[2];
  logic [17:0] m_wd[2], p_data[2];

  always @(posedge clk or negedge rst_n) begin : model
    logic [17:0] old_word[2];
    bit   [1:0]  old_rd[2];
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_addr[p] = 0; m_sel[p] = 0; m_rd[p] = 1; m_pipe[p] = 0;
        m_lanes[p] = 0; p_lanes[p] = 0; m_wd[p] = 0; p_data[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        old_word[p] = m_mem[m_addr[p]];
        old_rd[p]   = (m_sel[p] && m_rd[p]) ? m_lanes[p] : 2'b00;
      end
      for (int p = 0; p < 2; p++)
        if (m_sel[p] && !m_rd[p]) begin
          if (m_lanes[p][1]) m_mem[m_addr[p]][17:9] = m_wd[p][17:9];
          if (m_lanes[p][0]) m_mem[m_addr[p]][8:0]  = m_wd[p][8:0];
        end
      for (int p = 0; p < 2; p++) begin
        p_data[p]  = old_word[p];
        p_lanes[p] = old_rd[p];
        m_sel[p]   = !en_n[p] && en[p];
        m_rd[p]    = rnw[p];
        m_lanes[p] = {!hi_n[p], !lo_n[p]};
        m_pipe[p]  = pipe[p];
        m_wd[p]    = din[p];
        if (!clr_n[p])       m_addr[p] = 0;
        else if (!load_n[p]) m_addr[p] = int'(addr[p]);
        else if (!step_n[p]) m_addr[p] = (m_addr[p] == DEPTH - 1) ? 0 : m_addr[p] + 1;
      end
    end
  end

  task automatic cmp_port(input int p);
    logic [17:0] d;
    bit   [1:0]  l;
    if (m_pipe[p]) begin d = p_data[p]; l = p_lanes[p]; end
    else begin d = m_mem[m_addr[p]]; l = (m_sel[p] && m_rd[p]) ? m_lanes[p] : 2'b00; end
    if (oe_n[p]) l = 2'b00;
    if (!l[1]) d[17:9] = '0;
    if (!l[0]) d[8:0]  = '0;
    n_tests++;
    if (vld[p] !== l || dout[p] !== d) begin
      n_fail++;
      $display("FAIL %s port %0d: vld=%b dout=%h expected vld=%b dout=%h",
               tag, p, vld[p], dout[p], l, d);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_port(0);
    cmp_port(1);
  endtask

  task automatic idle(input int p);
    en_n[p] = 0; en[p] = 1; rnw[p] = 1; hi_n[p] = 1; lo_n[p] = 1;
    load_n[p] = 1; step_n[p] = 1; clr_n[p] = 1;
  endtask

  task automatic rd(input int p, input int a, input bit [1:0] lanes);
    idle(p);
    load_n[p] = 0; addr[p] = AW'(a);
    hi_n[p] = !lanes[1]; lo_n[p] = !lanes[0];
  endtask

  task automatic wr(input int p, input int a, input bit [1:0] lanes, input logic [17:0] d);
    rd(p, a, lanes);
    rnw[p] = 0; din[p] = d;
  endtask

  function automatic logic [17:0] pat(input int a, input int salt);
    return 18'((a * 37 + salt * 1013) ^ 'h2A5A5);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0;
    for (int p = 0; p < 2; p++) begin
      idle(p); oe_n[p] = 0; pipe[p] = 0; addr[p] = '0; din[p] = '0;
    end
    repeat (3) @(negedge clk);
    tag = "R12";                       // reset state: no lane valid
    cmp_port(0); cmp_port(1);
    rst_n = 1;

    // Burst fill through the counter, ending with a wrap to word 0.
    tag = "R10";
    wr(0, 0, 2'b11, pat(0, 0));
    tick();
    load_n[0] = 1; step_n[0] = 0;
    for (int i = 1; i <= DEPTH; i++) begin
      din[0] = pat(i % DEPTH, i / DEPTH);
      tick();
    end
    idle(0);
    rd(0, 0, 2'b11); tick();           // R10: word 0 holds the wrapped write
    rd(0, DEPTH - 1, 2'b11); tick();

    // Lane selection on reads, both ports, flow-through.
    tag = "R3";
    rd(0, 10, 2'b10); rd(1, 11, 2'b01); tick();
    tag = "R6";
    rd(0, 12, 2'b01); rd(1, 12, 2'b11); tick();
    rd(0, 13, 2'b00); rd(1, 14, 2'b10); tick();

    // Pipelined vs flow-through.
    tag = "R8";
    pipe[1] = 1;
    rd(0, 20, 2'b11); rd(1, 20, 2'b11); tick();
    rd(0, 21, 2'b11); rd(1, 22, 2'b11); tick();
    rd(1, 23, 2'b10); tick();
    idle(1); step_n[1] = 0; hi_n[1] = 0; lo_n[1] = 0; tick(); tick();
    pipe[0] = 1; pipe[1] = 0; rd(0, 30, 2'b11); rd(1, 31, 2'b11); tick(); tick();
    pipe[0] = 0;

    // Partial-lane writes and same-port read-back next cycle.
    tag = "R5";
    wr(0, 40, 2'b10, 18'h3FFFF); wr(1, 41, 2'b01, 18'h00000); tick();
    tag = "R11";
    rd(0, 40, 2'b11); rd(1, 41, 2'b11); tick();
    tick();

    // Cross-port collisions.
    tag = "R1";
    wr(0, 50, 2'b11, 18'h15555); rd(1, 50, 2'b11); tick();
    idle(0); rd(0, 50, 2'b11); rd(1, 50, 2'b11); tick();
    pipe[0] = 1;
    wr(1, 51, 2'b11, 18'h2AAAA); rd(0, 51, 2'b11); tick();
    idle(1); rd(1, 51, 2'b11); tick(); tick();
    pipe[0] = 0;
    wr(0, 52, 2'b10, 18'h3FE00); wr(1, 52, 2'b01, 18'h001FF); tick();
    rd(0, 52, 2'b11); rd(1, 52, 2'b11); tick();

    // Deselect by either enable.
    tag = "R4";
    wr(0, 60, 2'b11, 18'h12345); en_n[0] = 1; rd(1, 61, 2'b11); en[1] = 0; tick();
    rd(0, 60, 2'b11); rd(1, 61, 2'b11); tick();

    // Asynchronous output enable, checked between edges.
    tag = "R7";
    rd(0, 70, 2'b11); rd(1, 71, 2'b11); tick();
    oe_n[0] = 1; #1; cmp_port(0);
    oe_n[1] = 1; #1; cmp_port(1);
    oe_n[0] = 0; oe_n[1] = 0; #1; cmp_port(0); cmp_port(1);

    // Inputs between edges do not disturb the outputs.
    tag = "R2";
    rd(0, 80, 2'b01); wr(1, 70, 2'b11, 18'h0F0F0); #1; cmp_port(0); cmp_port(1);
    tick();

    // Counter priority.
    tag = "R9";
    rd(0, 90, 2'b11); clr_n[0] = 0; step_n[0] = 0; tick();
    rd(0, 91, 2'b11); step_n[0] = 0; tick();
    idle(0); hi_n[0] = 0; lo_n[0] = 0; step_n[0] = 0; tick();
    step_n[0] = 1; tick();
    rd(1, 100, 2'b11); tick();
    idle(1); lo_n[1] = 0; clr_n[1] = 0; tick();

    // Reset mid-run: address back to 0, memory kept.
    tag = "R12";
    rd(0, 120, 2'b11); tick();
    @(negedge clk); rst_n = 0; #1; cmp_port(0); cmp_port(1);
    @(negedge clk); rst_n = 1;
    idle(0); hi_n[0] = 0; lo_n[0] = 0; idle(1); lo_n[1] = 0; tick(); tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule